// File: doc/BRIEF.md
# USB Transmit Serializer

This block turns a stream of bytes from a link-side transmit interface into the bit-level symbol stream of a USB line. It runs on a byte-rate clock. A separate clock-enable input marks each bit time, and the block moves forward by one line symbol only when that enable is high. The link raises `tx_valid` with the first byte on `tx_data` and keeps a fresh byte ready for as long as `tx_valid` stays high. The block pulses `tx_ready` in the cycle whose closing clock edge consumes the byte on offer. When the link drops `tx_valid`, the block ends the packet with an end-of-packet sequence.

On the line side the block drives three outputs: a data level (`line_dat`, where 1 is the J state and 0 is the K state), a single-ended-zero flag, and an output enable. It frames each packet with a leading SYNC pattern. It sends every byte least significant bit first, adds stuff bits, applies NRZI coding and closes the packet with EOP. A mode input, sampled once at packet start, chooses one of three behaviours: full encoding, raw bits with no stuffing and no NRZI, or a non-driving mode in which the enable stays low. For a fixed number of clock edges after reset, the block ignores any request to transmit.

Top module: `usb_tx_serializer`

## Requirements
- R1: A packet opens with the SYNC pattern, the byte 0x80 sent least significant bit first (seven zeros, then a one) before any data, and passed through the same encoding as the data.
- R2: Data bits go out least significant bit first. `tx_ready` is high only in a bit-enable cycle whose closing edge takes `tx_data`, which happens once per byte and only while `tx_valid` is high.
- R3: In normal mode (`op_mode`=00), a zero is inserted after every run of six consecutive ones. This applies across byte boundaries and also just before EOP.
- R4: In normal mode the line starts each packet in J (`line_dat`=1). A zero toggles the line level and a one holds it, so the first SYNC symbol is K.
- R5: When `tx_valid` is low at a byte boundary (after any pending stuff bit), the line shows SE0 (`line_se0`=1, `line_dat`=0) for two bit times, then J (`line_se0`=0, `line_dat`=1) for one bit time. `line_oe` drops in the bit time after that.
- R6: In raw mode (`op_mode`=10), no stuff bits are inserted and `line_dat` equals the unencoded bit. SYNC and EOP are still sent.
- R7: In non-driving mode (`op_mode`=01), and in the reserved code 11, `line_oe` stays low for the whole packet, but bytes are still acknowledged through `tx_ready`.
- R8: The mode is latched when a packet starts. A change on `op_mode` during a packet has no effect on that packet.
- R9: After reset is released, `tx_valid` is ignored for the first 5 rising clock edges. With the bit enable held high and `tx_valid` already high, `line_oe` first rises after the 7th edge.
- R10: Reset acts asynchronously. While it is high, `line_oe`=0, `line_se0`=0, `line_dat`=1 and `tx_ready`=0.
- R11: The state and the line outputs change only on clock edges where `bit_en` is high. Each symbol holds for a whole bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock |
| rst | input | 1 | Reset, active high, asserted asynchronously, released synchronously |
| bit_en | input | 1 | Bit-time clock enable |
| tx_data | input | DATA_W | Byte offered by the link |
| tx_valid | input | 1 | Packet in progress / byte valid |
| tx_ready | output | 1 | Byte taken at the closing edge of this cycle |
| op_mode | input | 2 | 00 normal, 01 non-driving, 10 raw, 11 reserved (non-driving) |
| line_dat | output | 1 | Line data level, 1 = J |
| line_se0 | output | 1 | Single-ended-zero request |
| line_oe | output | 1 | Line output enable |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a stuffing run of six, two SE0 bit times and a five-edge reset gate. These values make stuffing reachable inside a byte, across a byte boundary and just before EOP. The bench runs the bit enable every clock, every second clock and every third clock. The slower rates make the hold of each symbol between ticks observable, and the every-clock rate makes the reset-gate edge count exact.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_NODRIVE = 2'b01,
    MODE_RAW     = 2'b10,
    MODE_RSVD    = 2'b11
  } tx_mode_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_ACTIVE,
    FR_EOP
  } fr_state_e;

  typedef enum logic [2:0] {
    SYM_NONE,
    SYM_BIT,
    SYM_STUFF,
    SYM_SE0,
    SYM_J
  } sym_e;

  // stuffing is applied only with full encoding
  function automatic logic mode_stuffs(tx_mode_e m);
    return m == MODE_NORMAL;
  endfunction

  function automatic logic mode_nrzi(tx_mode_e m);
    return m == MODE_NORMAL;
  endfunction

  // reserved code behaves like non-driving
  function automatic logic mode_drives(tx_mode_e m);
    return (m == MODE_NORMAL) || (m == MODE_RAW);
  endfunction

  // NRZI: a zero flips the level, a one keeps it
  function automatic logic nrzi_next(logic lvl, logic b);
    return b ? lvl : ~lvl;
  endfunction

endpackage

// File: rtl/tx_rst_gate.sv
module tx_rst_gate #(
  parameter int unsigned RST_GATE = 5
) (
  input  logic clk,
  input  logic rst,
  output logic gate_open
);
  localparam int unsigned GW = $clog2(RST_GATE + 1) > 0 ? $clog2(RST_GATE + 1) : 1;

  logic [GW-1:0] edge_cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      edge_cnt <= '0;
    end else if (edge_cnt != GW'(RST_GATE)) begin
      edge_cnt <= edge_cnt + GW'(1);
    end
  end

  assign gate_open = (edge_cnt == GW'(RST_GATE));

endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import usb_tx_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned EOP_SE0_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              gate_open,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [1:0]        op_mode,
  input  logic              stuff_due,
  output logic              tx_ready,
  output logic              pkt_start,
  output sym_e              sym,
  output logic              sym_bit,
  output tx_mode_e          mode_q
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam int unsigned EOP_W = $clog2(EOP_SE0_BITS + 1) > 0 ? $clog2(EOP_SE0_BITS + 1) : 1;
  localparam logic [DATA_W-1:0] SYNC_PAT = {1'b1, {(DATA_W-1){1'b0}}};

  fr_state_e         state, nx_state;
  logic [DATA_W-1:0] shreg, nx_shreg;
  logic [CNT_W-1:0]  remain, nx_remain;
  logic [EOP_W-1:0]  eop_cnt, nx_eop;
  tx_mode_e          nx_mode;
  logic              take, start;

  always_comb begin
    nx_state  = state;
    nx_shreg  = shreg;
    nx_remain = remain;
    nx_eop    = eop_cnt;
    nx_mode   = mode_q;
    sym       = SYM_NONE;
    sym_bit   = 1'b0;
    take      = 1'b0;
    start     = 1'b0;
    unique case (state)
      FR_IDLE: begin
        if (gate_open && tx_valid) begin
          nx_state  = FR_ACTIVE;
          nx_shreg  = SYNC_PAT;
          nx_remain = CNT_W'(DATA_W);
          nx_mode   = tx_mode_e'(op_mode);
          start     = 1'b1;
        end
      end
      FR_ACTIVE: begin
        if (stuff_due) begin
          sym = SYM_STUFF;
        end else if (remain != '0) begin
          sym       = SYM_BIT;
          sym_bit   = shreg[0];
          nx_shreg  = shreg >> 1;
          nx_remain = remain - CNT_W'(1);
        end else if (tx_valid) begin
          take      = 1'b1;
          sym       = SYM_BIT;
          sym_bit   = tx_data[0];
          nx_shreg  = tx_data >> 1;
          nx_remain = CNT_W'(DATA_W - 1);
        end else begin
          sym      = SYM_SE0;
          nx_state = FR_EOP;
          nx_eop   = EOP_W'(1);
        end
      end
      FR_EOP: begin
        if (eop_cnt < EOP_W'(EOP_SE0_BITS)) begin
          sym    = SYM_SE0;
          nx_eop = eop_cnt + EOP_W'(1);
        end else begin
          sym      = SYM_J;
          nx_state = FR_IDLE;
        end
      end
      default: nx_state = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= FR_IDLE;
      shreg   <= '0;
      remain  <= '0;
      eop_cnt <= '0;
      mode_q  <= MODE_NORMAL;
    end else if (bit_en) begin
      state   <= nx_state;
      shreg   <= nx_shreg;
      remain  <= nx_remain;
      eop_cnt <= nx_eop;
      mode_q  <= nx_mode;
    end
  end

  assign tx_ready  = bit_en && take;
  assign pkt_start = bit_en && start;

endmodule

// File: rtl/tx_stuffer.sv
module tx_stuffer
  import usb_tx_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 6,
  parameter int unsigned RUN_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             clear,
  input  logic             enable,
  input  sym_e             sym,
  input  logic             sym_bit,
  output logic             stuff_due,
  output logic [RUN_W-1:0] run_len
);
  generate
    if (STUFF_RUN > 0) begin : g_stuff
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          run_len <= '0;
        end else if (clear) begin
          run_len <= '0;
        end else if (bit_en) begin
          if (sym == SYM_BIT) begin
            if (!sym_bit)                          run_len <= '0;
            else if (run_len != RUN_W'(STUFF_RUN)) run_len <= run_len + RUN_W'(1);
          end else if (sym == SYM_STUFF) begin
            run_len <= '0;
          end
        end
      end
      assign stuff_due = enable && (run_len == RUN_W'(STUFF_RUN));
    end else begin : g_nostuff
      assign run_len   = '0;
      assign stuff_due = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/tx_line_drv.sv
module tx_line_drv
  import usb_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic pkt_start,
  input  sym_e sym,
  input  logic sym_bit,
  input  logic nrzi_en,
  input  logic drive_en,
  output logic line_dat,
  output logic line_se0,
  output logic line_oe
);
  logic lvl;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      line_dat <= 1'b1;
      line_se0 <= 1'b0;
      line_oe  <= 1'b0;
      lvl      <= 1'b1;
    end else if (bit_en) begin
      unique case (sym)
        SYM_BIT, SYM_STUFF: begin
          line_se0 <= 1'b0;
          line_oe  <= drive_en;
          if (nrzi_en) begin
            lvl      <= nrzi_next(lvl, sym_bit);
            line_dat <= nrzi_next(lvl, sym_bit);
          end else begin
            line_dat <= sym_bit;
          end
        end
        SYM_SE0: begin
          line_se0 <= 1'b1;
          line_dat <= 1'b0;
          line_oe  <= drive_en;
        end
        SYM_J: begin
          line_se0 <= 1'b0;
          line_dat <= 1'b1;
          line_oe  <= drive_en;
        end
        default: begin
          line_se0 <= 1'b0;
          line_dat <= 1'b1;
          line_oe  <= 1'b0;
          if (pkt_start) lvl <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer
  import usb_tx_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned STUFF_RUN    = 6,
  parameter int unsigned EOP_SE0_BITS = 2,
  parameter int unsigned RST_GATE     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [1:0]        op_mode,
  output logic              line_dat,
  output logic              line_se0,
  output logic              line_oe
);
  localparam int unsigned RUN_W = $clog2(STUFF_RUN + 1) > 0 ? $clog2(STUFF_RUN + 1) : 1;

  // internal events brought out for the checker
  logic             gate_open;
  logic             pkt_start;
  logic             stuff_due;
  logic             stuff_evt;
  logic             stuff_on;
  logic             nrzi_on;
  logic             drive_on;
  logic [RUN_W-1:0] run_len;
  sym_e             sym;
  logic             sym_bit;
  tx_mode_e         mode_q;

  tx_rst_gate #(.RST_GATE(RST_GATE)) u_gate (
    .clk(clk), .rst(rst), .gate_open(gate_open)
  );

  tx_framer #(.DATA_W(DATA_W), .EOP_SE0_BITS(EOP_SE0_BITS)) u_framer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .gate_open(gate_open),
    .tx_valid(tx_valid), .tx_data(tx_data), .op_mode(op_mode),
    .stuff_due(stuff_due), .tx_ready(tx_ready), .pkt_start(pkt_start),
    .sym(sym), .sym_bit(sym_bit), .mode_q(mode_q)
  );

  assign stuff_on  = mode_stuffs(mode_q);
  assign nrzi_on   = mode_nrzi(mode_q);
  assign drive_on  = mode_drives(mode_q);
  assign stuff_evt = bit_en && (sym == SYM_STUFF);

  tx_stuffer #(.STUFF_RUN(STUFF_RUN), .RUN_W(RUN_W)) u_stuff (
    .clk(clk), .rst(rst), .bit_en(bit_en), .clear(pkt_start),
    .enable(stuff_on), .sym(sym), .sym_bit(sym_bit),
    .stuff_due(stuff_due), .run_len(run_len)
  );

  tx_line_drv u_line (
    .clk(clk), .rst(rst), .bit_en(bit_en), .pkt_start(pkt_start),
    .sym(sym), .sym_bit(sym_bit), .nrzi_en(nrzi_on), .drive_en(drive_on),
    .line_dat(line_dat), .line_se0(line_se0), .line_oe(line_oe)
  );

endmodule

// File: rtl/usb_tx_serializer_chk.sv
module usb_tx_serializer_chk #(
  parameter int unsigned STUFF_RUN = 6,
  parameter int unsigned RUN_W     = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             line_dat,
  input logic             line_se0,
  input logic             line_oe,
  input logic             gate_open,
  input logic             stuff_evt,
  input logic             stuff_on,
  input logic             drive_on,
  input logic [RUN_W-1:0] run_len
);
  p_ready_valid_r2: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (tx_valid && bit_en));

  p_stuff_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    stuff_evt |=> (line_dat != $past(line_dat)));

  p_run_bound_r3: assert property (@(posedge clk) disable iff (rst)
    run_len <= RUN_W'(STUFF_RUN));

  p_eop_j_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(line_se0) |-> line_dat);

  p_raw_nostuff_r6: assert property (@(posedge clk) disable iff (rst)
    stuff_evt |-> stuff_on);

  p_nodrive_r7: assert property (@(posedge clk) disable iff (rst)
    !drive_on |=> !line_oe);

  p_gate_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !gate_open |-> !line_oe);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(line_dat) && $stable(line_se0) && $stable(line_oe)));

endmodule

bind usb_tx_serializer usb_tx_serializer_chk #(.STUFF_RUN(STUFF_RUN), .RUN_W(RUN_W)) i_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .line_dat(line_dat), .line_se0(line_se0), .line_oe(line_oe),
  .gate_open(gate_open), .stuff_evt(stuff_evt), .stuff_on(stuff_on),
  .drive_on(drive_on), .run_len(run_len)
);

// File: tb/test_usb_tx_serializer.sv
`timescale 1ns/1ps
module test_usb_tx_serializer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [1:0] op_mode = 2'b00;
  logic       line_dat, line_se0, line_oe;

  usb_tx_serializer i_usb_tx_serializer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .op_mode(op_mode), .line_dat(line_dat),
    .line_se0(line_se0), .line_oe(line_oe)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int bit_div = 1;
  int div_cnt = 0;
  logic tick_q = 1'b0;
  bit mon_en = 1'b0;
  bit first_sym = 1'b0;
  bit want_r4 = 1'b0;
  bit oe_seen = 1'b0;
  int acks = 0;
  string cur_req = "R1";
  logic [2:0] last_out = 3'b001;
  logic [1:0] exp_q[$];

  // reference model state
  int  m_ones = 0;
  bit  m_lvl = 1'b1;
  bit  m_raw = 1'b0;
  bit  m_drive = 1'b1;

  always @(posedge clk) begin
    div_cnt <= (div_cnt + 1 >= bit_div) ? 0 : div_cnt + 1;
    bit_en  <= (div_cnt == 0);
    tick_q  <= bit_en;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares each driven symbol {se0,dat}
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (tx_ready) acks++;
      if (line_oe) oe_seen = 1'b1;
      if (tick_q && line_oe) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected symbol", {line_se0, line_dat}, 0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          if (first_sym && want_r4)  // R4: first SYNC symbol is K
            chk({line_se0, line_dat} == 2'b00, "R4", "first symbol", {line_se0, line_dat}, 0);
          first_sym = 1'b0;
          chk({line_se0, line_dat} == e, cur_req, "symbol", {line_se0, line_dat}, e);
        end
      end
      if (!tick_q)  // R11: hold between ticks
        chk({line_oe, line_se0, line_dat} == last_out, "R11", "hold", {line_oe, line_se0, line_dat}, last_out);
      last_out = {line_oe, line_se0, line_dat};
    end
  end

  task automatic push_raw(input bit b);
    if (!m_drive) return;
    if (m_raw) begin
      exp_q.push_back({1'b0, b});
    end else begin
      if (b) m_ones++;
      else begin m_ones = 0; m_lvl = ~m_lvl; end
      exp_q.push_back({1'b0, m_lvl});
      if (m_ones == 6) begin
        m_ones = 0; m_lvl = ~m_lvl;
        exp_q.push_back({1'b0, m_lvl});
      end
    end
  endtask

  task automatic push_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) push_raw(v[i]);
  endtask

  task automatic send_packet(input logic [1:0] mode, input int div, input int n,
                             input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input bit swap_mode, input string req);
    logic [7:0] pb[3];
    int waitc;
    pb[0] = b0; pb[1] = b1; pb[2] = b2;
    bit_div = div;
    repeat (4) @(posedge clk);
    #1;
    cur_req = req;
    m_ones = 0; m_lvl = 1'b1;
    m_raw = (mode == 2'b10);
    m_drive = (mode == 2'b00) || (mode == 2'b10);
    want_r4 = (mode == 2'b00);
    first_sym = 1'b1; oe_seen = 1'b0; acks = 0;
    exp_q.delete();
    push_byte(8'h80);  // R1: SYNC
    op_mode = mode;
    tx_data = pb[0];
    tx_valid = 1'b1;
    mon_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tx_ready);
      push_byte(pb[i]);
      @(posedge clk); #1;
      if (swap_mode && i == 0) op_mode = 2'b01;  // R8: mid-packet change
      if (i + 1 < n) tx_data = pb[i+1];
      else begin
        tx_valid = 1'b0;
        if (m_drive) begin
          exp_q.push_back(2'b10); exp_q.push_back(2'b10); exp_q.push_back(2'b01);
        end
      end
    end
    waitc = 0;
    if (m_drive) begin
      do begin @(negedge clk); waitc++; end while ((exp_q.size() != 0 || line_oe) && waitc < 400);
    end else begin
      repeat (40 * div) @(negedge clk);
    end
    repeat (2 * div) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "all symbols incl. EOP sent", exp_q.size(), 0);
    chk(!line_oe, "R5", "oe dropped after EOP", line_oe, 0);
    chk(acks == n, "R2", "byte acknowledgements", acks, n);
    if (!m_drive) chk(!oe_seen, "R7", "oe stayed low", oe_seen, 0);
    else chk(oe_seen, req, "packet driven", oe_seen, 1);
    mon_en = 1'b0;
    op_mode = 2'b00;
  endtask

  initial begin
    int n;
    // R10: reset state
    tx_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!line_oe && !line_se0 && line_dat && !tx_ready, "R10", "reset outputs",
        {line_oe, line_se0, line_dat, tx_ready}, 3'b001 << 1);
    // R9: gate of 5 edges, first oe after 7th edge
    @(posedge clk); #1 rst = 1'b0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (line_oe) break;
    end
    chk(n == 7, "R9", "edges to first symbol", n, 7);
    tx_valid = 1'b0;
    repeat (40) @(posedge clk);

    send_packet(2'b00, 1, 3, 8'h2D, 8'h00, 8'hFF, 1'b0, "R1");
    send_packet(2'b00, 3, 1, 8'hFC, 8'h00, 8'h00, 1'b0, "R3");
    send_packet(2'b00, 1, 2, 8'hC0, 8'h0F, 8'h00, 1'b0, "R3");
    send_packet(2'b10, 2, 2, 8'hFF, 8'hA5, 8'h00, 1'b0, "R6");
    send_packet(2'b01, 1, 2, 8'h11, 8'h22, 8'h00, 1'b0, "R7");
    send_packet(2'b11, 2, 1, 8'h33, 8'h00, 8'h00, 1'b0, "R7");
    send_packet(2'b00, 1, 3, 8'h7E, 8'h81, 8'h55, 1'b1, "R8");
    send_packet(2'b00, 3, 2, 8'hA5, 8'hFE, 8'h00, 1'b0, "R11");

    // R10: asynchronous reset in the middle of a packet
    bit_div = 1;
    tx_data = 8'hFF; tx_valid = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(line_oe, "R10", "packet running before reset", line_oe, 1);
    #2 rst = 1'b1;
    #1;
    chk(!line_oe && !line_se0 && line_dat && !tx_ready, "R10", "async reset outputs",
        {line_oe, line_se0, line_dat, tx_ready}, 2);
    tx_valid = 1'b0;
    @(posedge clk); #1 rst = 1'b0;
    repeat (10) @(posedge clk);
    send_packet(2'b00, 2, 1, 8'h3C, 8'h00, 8'h00, 1'b0, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule